// File: doc/BRIEF.md
# Camera packet frame delimiter

This block sits behind a camera's isochronous packet receiver and turns a byte stream framed into packets into a byte stream marked with frame boundaries. Each input beat carries one byte, or flags a zero-length packet, together with start-of-packet and end-of-packet flags. A mode input, taken at the start of each packet, picks the rule used to find frame boundaries.

In compressed mode, a packet whose first two bytes are the start-of-image marker (0xFF then 0xD8) closes the running frame and opens the next. The two marker bytes are removed and the rest of the packet is passed on as data. Zero-length packets can occur in the middle of a compressed frame, so they are dropped without effect. In raw UYVY mode, every byte is passed on and a zero-length packet both ends one frame and starts the next.

Each output cycle carries one tagged item: a data byte, a frame-start pulse or a frame-end pulse. A small event queue absorbs the extra output cycle that a raw-mode empty packet costs, so the input never has to stall.

Top module: `cam_frame_delim`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `out_valid` is low. A reset also discards any item accepted before it but not yet emitted.
- R2: `out_tag` encodes 0 = data byte, 1 = frame start, 2 = frame end. The value 3 never appears while `out_valid` is high.
- R3: In compressed mode, a packet of two or more bytes that begins 0xFF, 0xD8 gives a frame end, then a frame start, then the packet's remaining bytes as data in order. The two marker bytes are never output.
- R4: In compressed mode, a zero-length packet produces no output item.
- R5: In compressed mode, a one-byte packet is forwarded unchanged as data, and a packet that starts 0xFF followed by a byte other than 0xD8 has both bytes forwarded as data.
- R6: In raw mode, every byte is forwarded as data, including a leading 0xFF, 0xD8 pair.
- R7: In raw mode, a zero-length packet produces a frame end followed by a frame start, and the bytes of the next packet follow as data.
- R8: Frame start and frame end are each one cycle long. A frame end is always followed in the next cycle by a frame start, and both come before the first data byte of the new frame.
- R9: The mode is taken from `mode_comp` on the start-of-packet beat, and a change of `mode_comp` within a packet has no effect on that packet.
- R10: With back-to-back input beats, no item is lost or duplicated as long as raw-mode empty packets outnumber idle input cycles by fewer than `FIFO_DEPTH` over any stretch of input.
- R11: With no backlog, a raw-mode data byte presented at one clock edge appears on the outputs after the next edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_empty | input | 1 | Beat stands for a zero-length packet. `in_data` is ignored |
| mode_comp | input | 1 | 1 = compressed mode, 0 = raw UYVY mode. Taken on start-of-packet beats |
| in_data | input | 8 | Packet byte |
| out_valid | output | 1 | Output item present |
| out_tag | output | 2 | Item kind: 0 data, 1 frame start, 2 frame end |
| out_data | output | 8 | Data byte, valid when the tag is data |

## Verification
The main stream mixes compressed packets that open with the marker, are a single 0xFF, or start 0xFF with a wrong second byte. This separates a correct two-byte match from a match on the first byte alone. Raw packets carry the same 0xFF, 0xD8 prefix, which shows that the marker rule is off in raw mode. Zero-length packets in both modes show which mode treats them as boundaries. Packets whose mode input flips after the first beat show that the mode is held per packet. A burst of consecutive raw empty packets followed by data fills the event queue and exposes any lost, reordered or repeated pulse.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SOI_FIRST  = 8'hFF;
  localparam logic [BYTE_W-1:0] SOI_SECOND = 8'hD8;

  typedef enum logic [1:0] {
    TAG_DATA = 2'd0,
    TAG_SOF  = 2'd1,
    TAG_EOF  = 2'd2
  } tag_e;

  // One queue entry: optional close/open pulses, then zero to two bytes.
  typedef struct packed {
    logic              close_f;
    logic              open_f;
    logic [1:0]        nbytes;
    logic [BYTE_W-1:0] b0;
    logic [BYTE_W-1:0] b1;
  } ev_t;

  localparam int EV_ITEMS = 4;

endpackage

// File: rtl/cfd_parser.sv
module cfd_parser
  import cfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_empty,
  input  logic              mode_comp,
  input  logic [BYTE_W-1:0] in_data,
  output logic              ev_push,
  output ev_t               ev
);

  logic hold_q, hold_d;
  logic pkt_mode_q;
  logic eff_mode;

  assign eff_mode = in_sop ? mode_comp : pkt_mode_q;

  always_comb begin
    ev_push = 1'b0;
    ev      = '0;
    hold_d  = hold_q;
    if (in_valid) begin
      if (hold_q) begin
        hold_d = 1'b0;
        if (in_empty) begin
          ev_push   = 1'b1;
          ev.nbytes = 2'd1;
          ev.b0     = SOI_FIRST;
        end else if (in_data == SOI_SECOND) begin
          ev_push    = 1'b1;
          ev.close_f = 1'b1;
          ev.open_f  = 1'b1;
        end else begin
          ev_push   = 1'b1;
          ev.nbytes = 2'd2;
          ev.b0     = SOI_FIRST;
          ev.b1     = in_data;
        end
      end else if (in_empty) begin
        if (!eff_mode) begin
          ev_push    = 1'b1;
          ev.close_f = 1'b1;
          ev.open_f  = 1'b1;
        end
      end else if (eff_mode && in_sop && !in_eop && in_data == SOI_FIRST) begin
        hold_d = 1'b1;
      end else begin
        ev_push   = 1'b1;
        ev.nbytes = 2'd1;
        ev.b0     = in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= 1'b0;
      pkt_mode_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (in_valid && in_sop)
        pkt_mode_q <= mode_comp;
    end
  end

endmodule

// File: rtl/cfd_evq.sv
module cfd_evq
  import cfd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  ev_t  wr_ev,
  input  logic pop,
  output ev_t  head,
  output logic empty,
  output logic full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ev_t           mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_en, rd_en;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign head  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wptr] <= wr_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= nxt(wptr);
      if (rd_en) rptr <= nxt(rptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cfd_expander.sv
module cfd_expander
  import cfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  ev_t               head,
  output logic              pop,
  output logic              out_valid,
  output logic [1:0]        out_tag,
  output logic [BYTE_W-1:0] out_data
);

  // Item order inside an entry: bit0 close, bit1 open, bit2 b0, bit3 b1
  logic [EV_ITEMS-1:0] done_q;
  logic [EV_ITEMS-1:0] items, todo, pick;
  logic                emit;

  assign items = {head.nbytes == 2'd2, head.nbytes != 2'd0, head.open_f, head.close_f};
  assign todo  = items & ~done_q;
  assign pick  = todo & (~todo + 1'b1);
  assign emit  = !q_empty && (todo != '0);
  assign pop   = emit && ((todo & ~pick) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= '0;
      out_valid <= 1'b0;
      out_tag   <= TAG_DATA;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (pop)
        done_q <= '0;
      else if (emit)
        done_q <= done_q | pick;
      if (emit) begin
        if (pick[0])      out_tag <= TAG_EOF;
        else if (pick[1]) out_tag <= TAG_SOF;
        else              out_tag <= TAG_DATA;
        out_data <= pick[3] ? head.b1 : (pick[2] ? head.b0 : '0);
      end
    end
  end

endmodule

// File: rtl/cam_frame_delim.sv
module cam_frame_delim
  import cfd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_empty,
  input  logic              mode_comp,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_tag,
  output logic [BYTE_W-1:0] out_data
);

  logic ev_push;
  ev_t  ev_data;
  ev_t  q_head;
  logic q_empty, q_full, q_pop;

  cfd_parser u_parse (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .mode_comp(mode_comp), .in_data(in_data),
    .ev_push(ev_push), .ev(ev_data)
  );

  cfd_evq #(.DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst(rst),
    .push(ev_push), .wr_ev(ev_data), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  cfd_expander u_exp (
    .clk(clk), .rst(rst),
    .q_empty(q_empty), .head(q_head), .pop(q_pop),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
  );

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
  import cfd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic [1:0] out_tag,
  input logic       ev_push,
  input logic       q_full
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_tag_legal_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag != 2'd3);

  assert_sof_after_eof_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == TAG_EOF) |=> (out_valid && out_tag == TAG_SOF));

  assert_sof_single_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == TAG_SOF) |=> !(out_valid && out_tag == TAG_SOF));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    ev_push |-> !q_full);

endmodule

bind cam_frame_delim cfd_checker u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_tag(out_tag),
  .ev_push(ev_push), .q_full(q_full)
);

// File: tb/sim_cam_frame_delim.sv
module sim_cam_frame_delim;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_empty = 1'b0, mode_comp = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic [1:0] out_tag;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  cam_frame_delim #(.FIFO_DEPTH(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .mode_comp(mode_comp), .in_data(in_data),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
  );

  // beat control: {valid, sop, eop, empty, mode_comp}
  localparam logic [4:0] IDLE  = 5'b00000;
  localparam logic [4:0] C_SOP = 5'b11001, C_MID = 5'b10001, C_EOP = 5'b10101;
  localparam logic [4:0] C_ONE = 5'b11101, C_EMP = 5'b11111;
  localparam logic [4:0] R_SOP = 5'b11000, R_MID = 5'b10000, R_EOP = 5'b10100;
  localparam logic [4:0] R_ONE = 5'b11100, R_EMP = 5'b11110;

  localparam int NB = 31;
  localparam logic [12:0] BEATS [NB] = '{
    {C_SOP, 8'hFF}, {C_MID, 8'hD8}, {C_MID, 8'h11}, {C_EOP, 8'h22},   // R3
    {IDLE,  8'h00},
    {C_EMP, 8'h00},                                                   // R4
    {C_ONE, 8'hFF},                                                   // R5
    {C_SOP, 8'hFF}, {C_MID, 8'h33}, {C_EOP, 8'h44},                   // R5
    {R_SOP, 8'hFF}, {R_MID, 8'hD8}, {R_EOP, 8'h55},                   // R6
    {R_EMP, 8'h00}, {R_ONE, 8'h66},                                   // R7
    {C_SOP, 8'hFF}, {R_MID, 8'hD8}, {R_EOP, 8'h77},                   // R9
    {R_SOP, 8'hFF}, {C_MID, 8'hD8}, {C_EOP, 8'h99},                   // R9
    {R_EMP, 8'h00}, {R_EMP, 8'h00}, {R_EMP, 8'h00}, {R_EMP, 8'h00},   // R10
    {R_SOP, 8'h88}, {R_EOP, 8'hAB},                                   // R10
    {C_SOP, 8'hFF}, {C_EOP, 8'hD8},                                   // R3
    {C_EMP, 8'h00}, {C_ONE, 8'h5A}                                    // R4
  };

  // expected item: {req code, tag, data}; tag 0 data, 1 start, 2 end
  localparam int NE = 33;
  localparam logic [13:0] EXPECT [NE] = '{
    {4'd3, 2'd2, 8'h00}, {4'd3, 2'd1, 8'h00}, {4'd3, 2'd0, 8'h11}, {4'd3, 2'd0, 8'h22},
    {4'd5, 2'd0, 8'hFF}, {4'd5, 2'd0, 8'hFF}, {4'd5, 2'd0, 8'h33}, {4'd5, 2'd0, 8'h44},
    {4'd6, 2'd0, 8'hFF}, {4'd6, 2'd0, 8'hD8}, {4'd6, 2'd0, 8'h55},
    {4'd7, 2'd2, 8'h00}, {4'd7, 2'd1, 8'h00}, {4'd7, 2'd0, 8'h66},
    {4'd9, 2'd2, 8'h00}, {4'd9, 2'd1, 8'h00}, {4'd9, 2'd0, 8'h77},
    {4'd9, 2'd0, 8'hFF}, {4'd9, 2'd0, 8'hD8}, {4'd9, 2'd0, 8'h99},
    {4'd10, 2'd2, 8'h00}, {4'd10, 2'd1, 8'h00}, {4'd10, 2'd2, 8'h00}, {4'd10, 2'd1, 8'h00},
    {4'd10, 2'd2, 8'h00}, {4'd10, 2'd1, 8'h00}, {4'd10, 2'd2, 8'h00}, {4'd10, 2'd1, 8'h00},
    {4'd10, 2'd0, 8'h88}, {4'd10, 2'd0, 8'hAB},
    {4'd3, 2'd2, 8'h00}, {4'd3, 2'd1, 8'h00},
    {4'd4, 2'd0, 8'h5A}
  };

  function automatic string rname(input logic [3:0] c);
    case (c)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  logic [9:0] got [128];
  int ng = 0, bad_tag = 0, bad_order = 0;
  bit prev_eof = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_eof = 1'b0;
    end else begin
      if (prev_eof && !(out_valid && out_tag == 2'd1)) bad_order++;
      prev_eof = out_valid && out_tag == 2'd2;
      if (out_valid) begin
        if (out_tag == 2'd3) bad_tag++;
        if (ng < 128) got[ng] = {out_tag, (out_tag == 2'd0) ? out_data : 8'h00};
        ng++;
      end
    end
  end

  task automatic drive(input logic [12:0] b);
    @(negedge clk);
    {in_valid, in_sop, in_eop, in_empty, mode_comp, in_data} = b;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R10 watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    // R1: quiet during and right after reset
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", out_valid, 0);

    // R1: reset discards an accepted but unemitted byte
    drive({R_ONE, 8'hC3});
    @(negedge clk);
    {in_valid, in_sop, in_eop, in_empty, mode_comp, in_data} = {IDLE, 8'h00};
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1", out_valid, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", out_valid, 0);

    // table walk
    base = ng;
    for (int i = 0; i < NB; i++) drive(BEATS[i]);
    drive({IDLE, 8'h00});
    repeat (20) @(negedge clk);

    check(ng - base == NE, "R10", ng - base, NE);
    for (int i = 0; i < NE; i++)
      check(got[base + i] == EXPECT[i][9:0], rname(EXPECT[i][13:10]),
            got[base + i], EXPECT[i][9:0]);

    // R11: one-edge latency through an idle pipeline
    drive({R_ONE, 8'h3C});
    @(negedge clk);
    {in_valid, in_sop, in_eop, in_empty, mode_comp, in_data} = {IDLE, 8'h00};
    check(!out_valid, "R11", out_valid, 0);
    @(negedge clk);
    check(out_valid && out_tag == 2'd0 && out_data == 8'h3C, "R11",
          {out_valid, out_tag, out_data}, {1'b1, 2'd0, 8'h3C});
    repeat (4) @(negedge clk);

    check(bad_tag == 0, "R2", bad_tag, 0);
    check(bad_order == 0, "R8", bad_order, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule